// File: doc/BRIEF.md
# Accumulator ALU with Status Flags

This block is the arithmetic and logic stage of a small single-accumulator controller datapath. Each cycle it can accept one operation. The operation combines the working register value, a register-file operand and an 8-bit literal. The block produces a registered result together with a write strobe that says where the result must be stored: the working register or the register-file location it was read from. It also holds the carry, digit-carry and zero status flags. Each operation class updates its own subset of these flags and leaves the others untouched.

The surrounding decode logic presents an operation code, a destination bit and the operands, then asserts `op_valid` for one cycle. The result, the two write strobes and the updated flags all appear together after the next rising clock edge. The register file and the working register capture `result` when their strobe is high. The carry flag is held inside the block, so rotate-through-carry and flag-preserving operations behave correctly across a sequence of operations.

Top module: `acc_alu`

## Requirements
- R1: Synchronous active-high reset clears `result`, both write strobes and all three flags. When `op_valid` is low at a rising edge, both strobes are low after that edge and the flags keep their values. When `op_valid` is high, all outputs reflect that operation after the same edge.
- R2: Operation codes fall into three groups. The register forms are 1, 3, 5, 7, 9, 10, 11, 12, 13, 16 and 17; for these, `dest_f`=0 raises `w_we` only and `dest_f`=1 raises `f_we` only. Codes 0, 2, 4, 6, 8, 14 and 18 always raise `w_we` only. Codes 15 and 19 always raise `f_we` only.
- R3: Code 0 computes W+k and code 1 computes W+f. Carry is set to the carry out of bit 7 and digit carry to the carry out of bit 3. Zero is set to (result==0).
- R4: Code 2 computes k−W and code 3 computes f−W, both in two's complement. Carry is 1 when no borrow occurs (minuend ≥ W). Digit carry is 1 when the low nibble of the minuend is ≥ the low nibble of W. Zero is set to (result==0).
- R5: Codes 4/5 compute AND, 6/7 inclusive OR and 8/9 XOR of W with k (even codes) or f (odd codes). Only Zero changes.
- R6: Code 10 gives the complement of f, 11 gives f+1, 12 gives f−1 and 13 passes f through, each wrapping modulo 256. Only Zero changes.
- R7: Code 14 clears W and code 15 clears f. Each writes 0 and forces Zero to 1; Carry and digit carry hold.
- R8: Code 16 rotates f left through carry. Result bit 0 takes the old Carry, the new Carry takes f bit 7, and only Carry changes.
- R9: Code 17 exchanges the upper and lower nibbles of f and changes no flag.
- R10: Code 18 loads k into W and code 19 copies W to f. Neither changes any flag.
- R11: Codes 20 to 31 raise no write strobe and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 5 | Operation selector |
| dest_f | input | 1 | Destination for register forms: 0 = W, 1 = f |
| w_in | input | 8 | Working register value |
| f_in | input | 8 | Register-file operand |
| k_in | input | 8 | Literal operand |
| result | output | 8 | Registered result |
| w_we | output | 1 | Write strobe for the working register |
| f_we | output | 1 | Write strobe for the register-file location |
| c_flag | output | 1 | Carry / no-borrow flag |
| dc_flag | output | 1 | Digit carry / nibble no-borrow flag |
| z_flag | output | 1 | Zero flag |

## Verification
The hardest situations to reach are the flag-preserving paths. A rotate, swap, clear or move only shows an error when the flags it must keep hold a value the faulty path would change. The bench therefore runs every operation code back to back in one long sequence, so the carry and digit-carry values left by additions and subtractions are inherited by later operations. Both values of every flag reach the preserving operations this way. Addition is also swept over all 65,536 operand pairs, and literal subtraction over a dense grid, so that nibble-boundary carries and exact-zero results occur many times.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  localparam int OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD_K  = 5'd0,
    OP_ADD_F  = 5'd1,
    OP_SUB_K  = 5'd2,
    OP_SUB_F  = 5'd3,
    OP_AND_K  = 5'd4,
    OP_AND_F  = 5'd5,
    OP_IOR_K  = 5'd6,
    OP_IOR_F  = 5'd7,
    OP_XOR_K  = 5'd8,
    OP_XOR_F  = 5'd9,
    OP_COM_F  = 5'd10,
    OP_INC_F  = 5'd11,
    OP_DEC_F  = 5'd12,
    OP_MOV_F  = 5'd13,
    OP_CLR_W  = 5'd14,
    OP_CLR_F  = 5'd15,
    OP_ROL_F  = 5'd16,
    OP_SWP_F  = 5'd17,
    OP_LIT_W  = 5'd18,
    OP_W_TO_F = 5'd19
  } alu_op_e;

  typedef struct packed {
    logic reg_form;
    logic wr_w;
    logic wr_f;
    logic arith;
    logic sub;
    logic lit_src;
    logic upd_c;
    logic upd_dc;
    logic upd_z;
    logic force_z;
    logic rot_c;
  } alu_ctl_t;

endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic            dest_f,
  output alu_ctl_t        ctl
);

  always_comb begin
    ctl = '0;
    case (op)
      OP_ADD_K:  begin ctl.arith = 1'b1; ctl.lit_src = 1'b1; ctl.upd_c = 1'b1; ctl.upd_dc = 1'b1; ctl.upd_z = 1'b1; end
      OP_ADD_F:  begin ctl.reg_form = 1'b1; ctl.arith = 1'b1; ctl.upd_c = 1'b1; ctl.upd_dc = 1'b1; ctl.upd_z = 1'b1; end
      OP_SUB_K:  begin ctl.arith = 1'b1; ctl.sub = 1'b1; ctl.lit_src = 1'b1; ctl.upd_c = 1'b1; ctl.upd_dc = 1'b1; ctl.upd_z = 1'b1; end
      OP_SUB_F:  begin ctl.reg_form = 1'b1; ctl.arith = 1'b1; ctl.sub = 1'b1; ctl.upd_c = 1'b1; ctl.upd_dc = 1'b1; ctl.upd_z = 1'b1; end
      OP_AND_K, OP_IOR_K, OP_XOR_K:
                 begin ctl.lit_src = 1'b1; ctl.upd_z = 1'b1; end
      OP_AND_F, OP_IOR_F, OP_XOR_F, OP_COM_F, OP_INC_F, OP_DEC_F, OP_MOV_F:
                 begin ctl.reg_form = 1'b1; ctl.upd_z = 1'b1; end
      OP_CLR_W:  begin ctl.upd_z = 1'b1; ctl.force_z = 1'b1; end
      OP_CLR_F:  begin ctl.wr_f = 1'b1; ctl.upd_z = 1'b1; ctl.force_z = 1'b1; end
      OP_ROL_F:  begin ctl.reg_form = 1'b1; ctl.upd_c = 1'b1; ctl.rot_c = 1'b1; end
      OP_SWP_F:  ctl.reg_form = 1'b1;
      OP_LIT_W:  ctl.lit_src = 1'b1;
      OP_W_TO_F: ctl.wr_f = 1'b1;
      default:   ctl = '0;
    endcase

    // Destination: register forms follow dest_f, the W-only group is fixed.
    if (ctl.reg_form) begin
      ctl.wr_w = ~dest_f;
      ctl.wr_f = dest_f;
    end else if (op == OP_CLR_W || (ctl.lit_src && op <= OP_LIT_W)) begin
      ctl.wr_w = 1'b1;
    end
  end

endmodule

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  input  logic             sub,
  output logic [WIDTH-1:0] sum,
  output logic             c_out,
  output logic             dc_out
);

  localparam int LO = WIDTH / 2;
  localparam int HI = WIDTH - LO;

  logic [WIDTH-1:0] b_eff;
  logic [LO:0]      lo_sum;
  logic [HI:0]      hi_sum;

  // Subtraction is a + ~b + 1, so carries come out as "no borrow".
  assign b_eff  = sub ? ~b : b;
  assign lo_sum = {1'b0, a[LO-1:0]} + {1'b0, b_eff[LO-1:0]} + {{LO{1'b0}}, sub};
  assign hi_sum = {1'b0, a[WIDTH-1:LO]} + {1'b0, b_eff[WIDTH-1:LO]} + {{HI{1'b0}}, lo_sum[LO]};

  assign sum    = {hi_sum[HI-1:0], lo_sum[LO-1:0]};
  assign dc_out = lo_sum[LO];
  assign c_out  = hi_sum[HI];

endmodule

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [OP_W-1:0]  op,
  input  logic [WIDTH-1:0] w,
  input  logic [WIDTH-1:0] f,
  input  logic [WIDTH-1:0] k,
  input  logic             c_in,
  output logic [WIDTH-1:0] res,
  output logic             rot_c
);

  localparam int LO = WIDTH / 2;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always_comb begin
    case (op)
      OP_AND_K:  res = w & k;
      OP_AND_F:  res = w & f;
      OP_IOR_K:  res = w | k;
      OP_IOR_F:  res = w | f;
      OP_XOR_K:  res = w ^ k;
      OP_XOR_F:  res = w ^ f;
      OP_COM_F:  res = ~f;
      OP_INC_F:  res = f + ONE;
      OP_DEC_F:  res = f - ONE;
      OP_MOV_F:  res = f;
      OP_ROL_F:  res = {f[WIDTH-2:0], c_in};
      OP_SWP_F:  res = {f[LO-1:0], f[WIDTH-1:LO]};
      OP_LIT_W:  res = k;
      OP_W_TO_F: res = w;
      default:   res = '0;
    endcase
  end

  assign rot_c = f[WIDTH-1];

endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             op_valid,
  input  logic [OP_W-1:0]  op_code,
  input  logic             dest_f,
  input  logic [WIDTH-1:0] w_in,
  input  logic [WIDTH-1:0] f_in,
  input  logic [WIDTH-1:0] k_in,
  output logic [WIDTH-1:0] result,
  output logic             w_we,
  output logic             f_we,
  output logic             c_flag,
  output logic             dc_flag,
  output logic             z_flag
);

  alu_ctl_t         ctl;
  logic [WIDTH-1:0] as_a, as_b, as_sum, lg_res, res_n;
  logic             as_c, as_dc, lg_c;
  logic             c_n, dc_n, z_n;

  acc_alu_ctrl u_ctrl (
    .op     (op_code),
    .dest_f (dest_f),
    .ctl    (ctl)
  );

  // Addition: W + operand. Subtraction: operand - W.
  assign as_a = ctl.sub ? (ctl.lit_src ? k_in : f_in) : w_in;
  assign as_b = ctl.sub ? w_in : (ctl.lit_src ? k_in : f_in);

  acc_alu_addsub #(.WIDTH(WIDTH)) u_addsub (
    .a      (as_a),
    .b      (as_b),
    .sub    (ctl.sub),
    .sum    (as_sum),
    .c_out  (as_c),
    .dc_out (as_dc)
  );

  acc_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op    (op_code),
    .w     (w_in),
    .f     (f_in),
    .k     (k_in),
    .c_in  (c_flag),
    .res   (lg_res),
    .rot_c (lg_c)
  );

  always_comb begin
    res_n = ctl.arith ? as_sum : lg_res;
    c_n   = c_flag;
    dc_n  = dc_flag;
    z_n   = z_flag;
    if (ctl.upd_c)  c_n  = ctl.rot_c ? lg_c : as_c;
    if (ctl.upd_dc) dc_n = as_dc;
    if (ctl.upd_z)  z_n  = ctl.force_z | (res_n == '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result  <= '0;
      w_we    <= 1'b0;
      f_we    <= 1'b0;
      c_flag  <= 1'b0;
      dc_flag <= 1'b0;
      z_flag  <= 1'b0;
    end else begin
      w_we <= op_valid & ctl.wr_w;
      f_we <= op_valid & ctl.wr_f;
      if (op_valid) begin
        if (ctl.wr_w | ctl.wr_f) result <= res_n;
        c_flag  <= c_n;
        dc_flag <= dc_n;
        z_flag  <= z_n;
      end
    end
  end

  a_r1_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> (!w_we && !f_we));

  a_r1_idle_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !op_valid |=> $stable({c_flag, dc_flag, z_flag}));

  a_r2_dest_steer: assert property (@(posedge clk) disable iff (rst)
    (op_valid && ctl.reg_form) |=> (f_we == $past(dest_f)) && (w_we == !$past(dest_f)));

  a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
    (op_valid && (op_code == OP_CLR_W || op_code == OP_CLR_F))
      |=> (result == '0) && z_flag && $stable({c_flag, dc_flag}));

  a_r8_rotate_carry: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_ROL_F)
      |=> (c_flag == $past(f_in[WIDTH-1])) && (result[0] == $past(c_flag)) && $stable({dc_flag, z_flag}));

  a_r9_swap_flags: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code == OP_SWP_F) |=> $stable({c_flag, dc_flag, z_flag}));

  a_r11_unused_quiet: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_code > OP_W_TO_F) |=> (!w_we && !f_we && $stable({c_flag, dc_flag, z_flag})));

endmodule

// File: tb/sim_acc_alu.sv
module sim_acc_alu;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic       dest_f = 1'b0;
  logic [7:0] w_in = '0, f_in = '0, k_in = '0;
  logic [7:0] result;
  logic       w_we, f_we, c_flag, dc_flag, z_flag;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  // Bench model of the flags
  bit mc = 0, mdc = 0, mz = 0;

  always #10 clk = ~clk;

  acc_alu u0 (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code), .dest_f(dest_f),
    .w_in(w_in), .f_in(f_in), .k_in(k_in), .result(result),
    .w_we(w_we), .f_we(f_we), .c_flag(c_flag), .dc_flag(dc_flag), .z_flag(z_flag)
  );

  function automatic string tag_of(input int op);
    if (op <= 1)  return "R3";
    if (op <= 3)  return "R4";
    if (op <= 9)  return "R5";
    if (op <= 13) return "R6";
    if (op <= 15) return "R7";
    if (op == 16) return "R8";
    if (op == 17) return "R9";
    if (op <= 19) return "R10";
    return "R11";
  endfunction

  task automatic run_op(input int op, input int d, input int w, input int f, input int k);
    int  a, b, r;
    bit  ew, ef, ec, edc, ez;
    bit  regf;
    bit  ok;
    // drive at a falling edge
    op_valid = 1'b1; op_code = 5'(op); dest_f = d[0];
    w_in = 8'(w); f_in = 8'(f); k_in = 8'(k);
    ec = mc; edc = mdc; ez = mz; r = 0;
    regf = (op inside {1, 3, 5, 7, 9, 10, 11, 12, 13, 16, 17});
    ew = regf ? (d == 0) : (op inside {0, 2, 4, 6, 8, 14, 18});
    ef = regf ? (d == 1) : (op inside {15, 19});
    case (op)
      0, 1: begin
        b = (op == 0) ? k : f;
        r = (w + b) % 256; ec = (w + b) > 255; edc = ((w % 16) + (b % 16)) > 15; ez = (r == 0);
      end
      2, 3: begin
        a = (op == 2) ? k : f;
        r = (a - w + 256) % 256; ec = (a >= w); edc = ((a % 16) >= (w % 16)); ez = (r == 0);
      end
      4, 5:   begin r = w & ((op == 4) ? k : f); ez = (r == 0); end
      6, 7:   begin r = w | ((op == 6) ? k : f); ez = (r == 0); end
      8, 9:   begin r = w ^ ((op == 8) ? k : f); ez = (r == 0); end
      10:     begin r = 255 - f; ez = (r == 0); end
      11:     begin r = (f + 1) % 256; ez = (r == 0); end
      12:     begin r = (f + 255) % 256; ez = (r == 0); end
      13:     begin r = f; ez = (r == 0); end
      14, 15: begin r = 0; ez = 1; end
      16:     begin r = ((f * 2) % 256) + (mc ? 1 : 0); ec = (f >= 128); end
      17:     begin r = ((f % 16) * 16) + (f / 16); end
      18:     r = k;
      19:     r = w;
      default: r = 0;
    endcase
    @(negedge clk);
    checks++;
    if (w_we !== ew || f_we !== ef) begin
      fails++;
      $display("FAIL R2 op=%0d d=%0d: we(w,f) got %b%b exp %b%b", op, d, w_we, f_we, ew, ef);
    end
    ok = (c_flag === ec) && (dc_flag === edc) && (z_flag === ez);
    if ((ew || ef) && result !== 8'(r)) ok = 0;
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s op=%0d d=%0d w=%h f=%h k=%h: got res=%h c/dc/z=%b%b%b exp res=%h c/dc/z=%b%b%b",
               tag_of(op), op, d, w[7:0], f[7:0], k[7:0], result, c_flag, dc_flag, z_flag,
               r[7:0], ec, edc, ez);
    end
    mc = ec; mdc = edc; mz = ez;
  endtask

  task automatic idle_check(input int op);
    op_valid = 1'b0; op_code = 5'(op); dest_f = 1'b1; f_in = 8'h00; w_in = 8'h00; k_in = 8'h00;
    @(negedge clk);
    checks++;
    if (w_we !== 1'b0 || f_we !== 1'b0 || c_flag !== mc || dc_flag !== mdc || z_flag !== mz) begin
      fails++;
      $display("FAIL R1 idle: got we=%b%b c/dc/z=%b%b%b exp we=00 c/dc/z=%b%b%b",
               w_we, f_we, c_flag, dc_flag, z_flag, mc, mdc, mz);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    checks++;
    if (result !== 8'h00 || w_we !== 1'b0 || f_we !== 1'b0 ||
        c_flag !== 1'b0 || dc_flag !== 1'b0 || z_flag !== 1'b0) begin
      fails++;
      $display("FAIL R1 reset: got res=%h we=%b%b c/dc/z=%b%b%b exp all zero",
               result, w_we, f_we, c_flag, dc_flag, z_flag);
    end
    // All codes, both destinations, mixed operands; flags carry over between operations
    for (int op = 0; op < 23; op++)
      for (int d = 0; d < 2; d++)
        for (int i = 0; i < 16; i++)
          for (int j = 0; j < 16; j++)
            run_op(op, d, i * 17, (j * 37 + i * 5) % 256, (j * 53 + 11) % 256);
    // R1: idle cycles after setting flags
    run_op(1, 0, 8'hff, 8'h01, 0);
    idle_check(0);
    idle_check(15);
    run_op(2, 0, 8'h01, 0, 8'h00);
    idle_check(14);
    // R3: exhaustive register-form addition
    for (int w = 0; w < 256; w++)
      for (int f = 0; f < 256; f++)
        run_op(1, (w ^ f) & 1, w, f, 0);
    // R4: dense grid of literal subtraction, including equal operands
    for (int w = 0; w < 256; w += 3)
      for (int k = 0; k < 256; k += 3)
        run_op(2, 0, w, 0, k);
    // R8: rotate chain through carry
    for (int i = 0; i < 20; i++) run_op(16, i & 1, 0, (i * 97) % 256, 0);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule